// File: doc/BRIEF.md
# SPI Byte-Memory Target

This block is an SPI target in front of a 512-byte on-chip memory. A host selects it with an active-low chip select and sends a command byte, then an address byte, then any number of data bytes. Reads and writes run at the speed of the serial clock, so the host never has to poll for a ready state. A write-enable latch, set and cleared by two one-byte commands, guards every write. A host can also pause a transfer in the middle with an active-low hold input.

The serial pins are sampled by a faster system clock through synchronizers, and all internal state runs on that clock. The serial clock must therefore stay at most one eighth of the system clock rate, with each serial clock phase lasting at least four system clocks. The output has a separate drive-enable, so several targets can share one data-out line.

Top module: `spi_mem_target`

## Requirements
- R1: After reset, `so_oe` is 0 and `wel` is 0.
- R2: The command byte 0x06 sets `wel` and the command byte 0x04 clears it. Each takes effect once the eighth command bit has been received.
- R3: The command `0000_A010` followed by an address byte stores each following byte in memory when its eighth bit arrives, but only if `wel` was 1 when the command completed. Otherwise the data bytes leave memory unchanged.
- R4: The command `0000_A011` followed by an address byte returns memory bytes on `so`, most significant bit first. Each bit is driven after a falling edge of `sck` and is valid at the next rising edge. `so_oe` is 1 only during this data phase.
- R5: The address is 9 bits wide. Bit 8 comes from bit 3 of the command byte (A), and bits 7..0 come from the address byte.
- R6: During both reads and writes, the address advances by one after each data byte and wraps from 0x1FF to 0x000.
- R7: Modes 0 and 3 both work. The mode is taken from the level of `sck` at each falling edge of `csn`. In mode 3, the first falling edge of `sck` after select is ignored.
- R8: Only the first byte after select is decoded. Bytes that follow 0x06 or 0x04 are ignored. After any other unknown command byte, all bytes are ignored until `csn` rises.
- R9: `wel` returns to 0 when `csn` rises at the end of a write command.
- R10: If `hold_n` goes low while `sck` is low, `sck` edges are ignored and `so_oe` is 0. When `hold_n` is released while `sck` is low, the transfer resumes with no bit lost or repeated.
- R11: `so_oe` is 0 whenever `csn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| csn | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive-enable for `so` |
| wel | output | 1 | Write-enable latch state |

## Verification
Two events can fall in the same system cycle: committing a write byte to memory, and the address advancing, including the wrap from 0x1FF to 0x000. The bench provokes this by writing two bytes starting at 0x1FF and then reading both back from 0x1FF. Both bytes must land at their own addresses, and the readback must cross the wrap in the same order. A hold held during pulses of `sck` in the middle of a read byte and of a write byte is judged the same way: the returned and stored values must be exactly those that would be seen without the pause.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MEM_AW = 9;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADR,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] CMD_SET_WE = 8'h06;
  localparam logic [7:0] CMD_CLR_WE = 8'h04;
  localparam logic [7:0] CMD_HI_MSK = 8'hF7;
  localparam logic [7:0] CMD_RD_BAS = 8'h03;
  localparam logic [7:0] CMD_WR_BAS = 8'h02;

  function automatic logic is_rd_cmd(input logic [7:0] b);
    return (b & CMD_HI_MSK) == CMD_RD_BAS;
  endfunction

  function automatic logic is_wr_cmd(input logic [7:0] b);
    return (b & CMD_HI_MSK) == CMD_WR_BAS;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
    end
    assign pin_o[g] = chain_q[LAST];
  end
endmodule

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int unsigned AW = MEM_AW,
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_s,
  input  logic          csn_s,
  input  logic          si_s,
  input  logic          hold_s,
  input  logic [DW-1:0] rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] ram_raddr,
  output logic          so,
  output logic          so_oe,
  output logic          wel
);
  localparam int unsigned BCW   = $clog2(DW);
  localparam int unsigned HIW   = AW - DW;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  phase_t         ph_q;
  logic           sck_d, csn_d;
  logic           hold_q;
  logic           mode3_q, seen_rise_q;
  logic [BCW-1:0] bitcnt_q;
  logic [DW-1:0]  shift_q, out_byte_q;
  logic [HIW-1:0] ahi_q;
  logic [AW-1:0]  addr_q;
  logic           rd_cmd_q, wr_cmd_q, wr_ok_q;
  logic           wel_q, oe_q, so_q;
  logic           we_q;
  logic [AW-1:0]  waddr_q;
  logic [DW-1:0]  wdata_q;

  logic          cs_act, cs_fall, cs_rise;
  logic          rise_ev, fall_ev, byte_done;
  logic [DW-1:0] shift_nxt;

  assign cs_act    = !csn_s;
  assign cs_fall   = csn_d && !csn_s;
  assign cs_rise   = !csn_d && csn_s;
  assign rise_ev   = cs_act && !cs_fall && !sck_d && sck_s && !hold_q;
  assign fall_ev   = cs_act && !cs_fall && sck_d && !sck_s && !hold_q
                     && !(mode3_q && !seen_rise_q);
  assign shift_nxt = {shift_q[DW-2:0], si_s};
  assign byte_done = rise_ev && (bitcnt_q == LAST_BIT);

  // pin history and hold tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
      if (!sck_s) hold_q <= !hold_s;
    end
  end

  // mode capture at select
  always_ff @(posedge clk) begin
    if (rst) begin
      mode3_q     <= 1'b0;
      seen_rise_q <= 1'b0;
    end else if (cs_fall) begin
      mode3_q     <= sck_s;
      seen_rise_q <= 1'b0;
    end else if (rise_ev) begin
      seen_rise_q <= 1'b1;
    end
  end

  // receive shifter and command sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_CMD;
      bitcnt_q <= '0;
      shift_q  <= '0;
      ahi_q    <= '0;
      addr_q   <= '0;
      rd_cmd_q <= 1'b0;
      wr_cmd_q <= 1'b0;
      wr_ok_q  <= 1'b0;
      wel_q    <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (!cs_act) begin
        ph_q     <= PH_CMD;
        bitcnt_q <= '0;
        if (cs_rise && wr_cmd_q) wel_q <= 1'b0;
        wr_cmd_q <= 1'b0;
      end else if (rise_ev) begin
        shift_q  <= shift_nxt;
        bitcnt_q <= bitcnt_q + 1'b1;
        if (byte_done) begin
          unique case (ph_q)
            PH_CMD: begin
              if (shift_nxt == CMD_SET_WE) begin
                wel_q <= 1'b1;
                ph_q  <= PH_SKIP;
              end else if (shift_nxt == CMD_CLR_WE) begin
                wel_q <= 1'b0;
                ph_q  <= PH_SKIP;
              end else if (is_rd_cmd(shift_nxt) || is_wr_cmd(shift_nxt)) begin
                ahi_q    <= shift_nxt[3 +: HIW];
                rd_cmd_q <= is_rd_cmd(shift_nxt);
                wr_cmd_q <= is_wr_cmd(shift_nxt);
                wr_ok_q  <= wel_q;
                ph_q     <= PH_ADR;
              end else begin
                ph_q <= PH_SKIP;
              end
            end
            PH_ADR: begin
              addr_q <= {ahi_q, shift_nxt};
              ph_q   <= rd_cmd_q ? PH_RD : PH_WR;
            end
            PH_WR: begin
              we_q    <= wr_ok_q;
              waddr_q <= addr_q;
              wdata_q <= shift_nxt;
              addr_q  <= addr_q + 1'b1;
            end
            PH_RD: begin
              addr_q <= addr_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // transmit path: change on falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q       <= 1'b0;
      so_q       <= 1'b0;
      out_byte_q <= '0;
    end else if (!cs_act) begin
      oe_q <= 1'b0;
    end else if (fall_ev && ph_q == PH_RD) begin
      oe_q <= 1'b1;
      if (bitcnt_q == '0) begin
        out_byte_q <= rdata;
        so_q       <= rdata[DW-1];
      end else begin
        so_q <= out_byte_q[LAST_BIT - bitcnt_q];
      end
    end
  end

  assign ram_we    = we_q;
  assign ram_waddr = waddr_q;
  assign ram_wdata = wdata_q;
  assign ram_raddr = addr_q;
  assign so        = so_q;
  assign so_oe     = oe_q && !hold_q;
  assign wel       = wel_q;

  AST_WREN_SETS: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_CMD && byte_done && shift_nxt == CMD_SET_WE) |=> wel_q); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_RD || ph_q == PH_WR) && byte_done && addr_q == '1) |=> addr_q == '0); // R6
  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SKIP && cs_act) |=> (ph_q == PH_SKIP || csn_s)); // R8
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && wr_cmd_q) |=> !wel_q); // R9
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (hold_q && $past(hold_q) && cs_act && $past(cs_act)) |-> $stable(bitcnt_q)); // R10
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !oe_q); // R11
endmodule

// File: rtl/spi_mem_target.sv
module spi_mem_target
  import spi_mem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csn,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe,
  output logic wel
);
  localparam int unsigned PINS = 4;

  logic [PINS-1:0]   pins_s;
  logic              ram_we;
  logic [MEM_AW-1:0] ram_waddr, ram_raddr;
  logic [BYTE_W-1:0] ram_wdata, ram_rdata;

  spi_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_i ({hold_n, si, csn, sck}),
    .pin_o (pins_s)
  );

  spi_mem_ctrl #(.AW(MEM_AW), .DW(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (pins_s[0]),
    .csn_s     (pins_s[1]),
    .si_s      (pins_s[2]),
    .hold_s    (pins_s[3]),
    .rdata     (ram_rdata),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ram_raddr (ram_raddr),
    .so        (so),
    .so_oe     (so_oe),
    .wel       (wel)
  );

  spi_byte_ram #(.AW(MEM_AW), .DW(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );
endmodule

// File: tb/test_spi_mem_target.sv
module test_spi_mem_target;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, wel;

  int n_chk = 0, n_fail = 0;
  int idle_cnt = 0;
  bit done = 1'b0;
  bit mode3 = 1'b0;
  logic [7:0] model [512];

  always #2 clk = ~clk;

  spi_mem_target i_spi_mem_target (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .wel(wel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every clock: idle select means no drive (R11)
  always @(negedge clk) begin
    if (rst || !csn) idle_cnt = 0;
    else idle_cnt++;
    if (idle_cnt > 4 && !done) chk(so_oe == 1'b0, "R11 oe idle", so_oe, 0);
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    mode3 = m3;
    sck = m3; wt(H);
    csn = 1'b0; wt(H);
    if (m3) begin sck = 1'b0; wt(H); end
  endtask

  task automatic desel();
    if (mode3) begin sck = 1'b1; wt(H); end
    else wt(H);
    csn = 1'b1; wt(4 * H);
    sck = 1'b0;
  endtask

  task automatic do_hold(input bit rd);
    hold_n = 1'b0; wt(H);
    if (rd) chk(so_oe == 1'b0, "R10 oe in hold", so_oe, 0);
    for (int p = 0; p < 2; p++) begin
      sck = 1'b1; wt(H); sck = 1'b0; wt(H);
    end
    hold_n = 1'b1; wt(H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output bit oe_all, input int hold_at, input bit rd);
    oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i == hold_at) do_hold(rd);
      si = tx[7 - i]; wt(H);
      rx[7 - i] = so;
      if (!so_oe) oe_all = 1'b0;
      sck = 1'b1; wt(H);
      sck = 1'b0;
    end
  endtask

  task automatic one_cmd(input bit m3, input logic [7:0] c);
    logic [7:0] r; bit o;
    sel(m3); xfer(c, r, o, -1, 1'b0); desel();
  endtask

  task automatic wr(input bit m3, input logic [8:0] a, input logic [7:0] d0,
                    input logic [7:0] d1, input int nb, input int hold_at);
    logic [7:0] r; bit o;
    sel(m3);
    xfer({4'h0, a[8], 3'b010}, r, o, -1, 1'b0);
    xfer(a[7:0], r, o, -1, 1'b0);
    xfer(d0, r, o, hold_at, 1'b0);
    if (nb > 1) xfer(d1, r, o, -1, 1'b0);
    desel();
  endtask

  task automatic rd_chk(input bit m3, input logic [8:0] a, input int nb,
                        input int hold_at, input string req);
    logic [7:0] r; bit o;
    logic [8:0] p;
    p = a;
    sel(m3);
    xfer({4'h0, a[8], 3'b011}, r, o, -1, 1'b0);
    xfer(a[7:0], r, o, -1, 1'b0);
    for (int b = 0; b < nb; b++) begin
      xfer(8'h00, r, o, (b == 0) ? hold_at : -1, 1'b1);
      chk(r === model[p], req, r, model[p]);
      chk(o == 1'b1, {req, " R4 oe"}, o, 1);
      p = p + 9'd1;
    end
    desel();
  endtask

  initial begin
    wt(5); rst = 1'b0; wt(2);
    chk(so_oe == 1'b0, "R1 oe", so_oe, 0);
    chk(wel == 1'b0, "R1 wel", wel, 0);

    one_cmd(1'b0, 8'h06);
    chk(wel == 1'b1, "R2 set", wel, 1);
    wr(1'b0, 9'h020, 8'h11, 8'h00, 1, -1); model[9'h020] = 8'h11;
    chk(wel == 1'b0, "R9 clear", wel, 0);
    wr(1'b0, 9'h020, 8'hEE, 8'h00, 1, -1);
    rd_chk(1'b0, 9'h020, 1, -1, "R3 no-wel write ignored");

    one_cmd(1'b0, 8'h06);
    wr(1'b0, 9'h010, 8'hA5, 8'h3C, 2, -1);
    model[9'h010] = 8'hA5; model[9'h011] = 8'h3C;
    rd_chk(1'b0, 9'h010, 2, -1, "R4 read");

    one_cmd(1'b0, 8'h06);
    wr(1'b0, 9'h110, 8'h77, 8'h00, 1, -1); model[9'h110] = 8'h77;
    rd_chk(1'b0, 9'h110, 1, -1, "R5 high page");
    rd_chk(1'b0, 9'h010, 1, -1, "R5 low page");

    one_cmd(1'b0, 8'h06);
    wr(1'b0, 9'h1FF, 8'hC1, 8'hC2, 2, -1);
    model[9'h1FF] = 8'hC1; model[9'h000] = 8'hC2;
    rd_chk(1'b0, 9'h1FF, 2, -1, "R6 wrap");

    one_cmd(1'b1, 8'h06);
    chk(wel == 1'b1, "R7 mode3 cmd", wel, 1);
    wr(1'b1, 9'h033, 8'h96, 8'h00, 1, -1); model[9'h033] = 8'h96;
    rd_chk(1'b1, 9'h033, 1, -1, "R7 mode3 read");
    rd_chk(1'b0, 9'h033, 1, -1, "R7 mode0 after mode3");

    begin
      logic [7:0] r; bit o;
      sel(1'b0); xfer(8'h06, r, o, -1, 1'b0); xfer(8'h04, r, o, -1, 1'b0); desel();
      chk(wel == 1'b1, "R8 trailing byte", wel, 1);
      one_cmd(1'b0, 8'h04);
      chk(wel == 1'b0, "R2 clear", wel, 0);
      sel(1'b0); xfer(8'h83, r, o, -1, 1'b0); xfer(8'h06, r, o, -1, 1'b0); desel();
      chk(wel == 1'b0, "R8 unknown cmd", wel, 0);
      one_cmd(1'b0, 8'h06);
      sel(1'b0); xfer(8'h12, r, o, -1, 1'b0); xfer(8'h02, r, o, -1, 1'b0);
      xfer(8'h20, r, o, -1, 1'b0); xfer(8'h55, r, o, -1, 1'b0); desel();
      chk(wel == 1'b1, "R8 unknown keeps wel", wel, 1);
      rd_chk(1'b0, 9'h020, 1, -1, "R8 no write after unknown");
    end

    rd_chk(1'b0, 9'h010, 2, 3, "R10 read across hold");
    wr(1'b0, 9'h040, 8'h6B, 8'h00, 1, 5); model[9'h040] = 8'h6B;
    rd_chk(1'b0, 9'h040, 1, -1, "R10 write across hold");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule